// File: doc/BRIEF.md
# Two-Port GPIO Block with Die-to-Die Pin Takeover

This block gives a chip two small general-purpose I/O ports behind a single-cycle register bus. One is a control port two pins wide and the other is a data port eight pins wide. Software sets each pin's stored output value and its direction through four registers. Input pins pass through a two-flop synchronizer before software reads them. On a read, a pin set as output returns its stored bit, and a pin set as input returns its synchronized level.

A die-to-die interface can claim pins at run time. When it is enabled, it takes both control-port pins: the upper pin carries its interrupt line and the lower pin carries its clock. In wide mode it takes all eight data-port pins. In narrow mode it takes only the lower four, and the upper four stay general-purpose. On a claimed pin, the output value and output enable come from the interface. Bus writes still land in the stored registers, and those values reappear on the pin once the interface releases it.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset all four registers hold zero, and with the interface disabled every output enable is low.
- R2: The register map is: control-port data at 0x04, data-port data at 0x05, control-port direction at 0x06 and data-port direction at 0x07. Each register can be written and read in any cycle, and a write takes effect at the next clock edge.
- R3: The control-port registers keep only bits 1:0. Bits 7:2 read as zero and ignore written ones.
- R4: On a data-register read, a pin whose direction bit is 1 returns its stored data bit.
- R5: On a data-register read, a pin whose direction bit is 0 returns the pin level from two clock edges earlier. A change on the pin is not visible after one edge and is visible after the second.
- R6: Reads at any address outside 0x04 to 0x07 return zero, and writes there change no register.
- R7: A pin that is not claimed drives its stored data bit as its output and its direction bit as its output enable.
- R8: With the interface enabled, control-port pin 1 output and enable follow the interrupt signal (bit 1 of the control alternate vector), and pin 0 follows the clock signal (bit 0).
- R9: With the interface enabled in wide mode, all eight data-port pins take output and enable from the interface data vector, bit for bit.
- R10: With the interface enabled in narrow mode, data-port pins 3:0 follow the interface and pins 7:4 follow their own data and direction registers.
- R11: A write to a data or direction register while the interface owns the pin still updates the stored bit. The new value drives the pin once the interface is disabled, and it reads back when the direction bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| pc_in | input | 2 | Control-port pin levels |
| pc_out | output | 2 | Control-port pin output values |
| pc_oe | output | 2 | Control-port pin output enables |
| pd_in | input | 8 | Data-port pin levels |
| pd_out | output | 8 | Data-port pin output values |
| pd_oe | output | 8 | Data-port pin output enables |
| alt_en | input | 1 | Interface enable: claims pins when high |
| alt_wide | input | 1 | 1 = eight data pins claimed, 0 = lower four |
| alt_ctl_out | input | 2 | Interface outputs: bit 1 interrupt, bit 0 clock |
| alt_ctl_oe | input | 2 | Interface output enables for the control pins |
| alt_dat_out | input | 8 | Interface data outputs |
| alt_dat_oe | input | 8 | Interface data output enables |

## Verification
The bench builds the block with its defaults: base address 0x04, an eight-pin data port split at bit 4 in narrow mode, and a two-stage synchronizer. With the split at 4, one enable pattern shows interface-driven and register-driven pins side by side in a single data-port value. With two stages, the bench can see the read value before and after the second clock edge. Mixed direction masks combine stored bits with synchronized pin levels in one read.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
// Package: shared register-select type and offset decode for the GPIO port block.
// Assumes four consecutive registers starting at a base address.
package gpio_port_pkg;

    localparam int NUM_REGS = 4;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_C_DATA,
        RSEL_D_DATA,
        RSEL_C_DIR,
        RSEL_D_DIR
    } reg_sel_e;

    // Map a register offset to its select value.
    function automatic reg_sel_e sel_from_offset(input logic [1:0] off);
        case (off)
            2'd0:    return RSEL_C_DATA;
            2'd1:    return RSEL_D_DATA;
            2'd2:    return RSEL_C_DIR;
            default: return RSEL_D_DIR;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Module: gpio_sync
// Multi-stage flop synchronizer for a vector of pin inputs.
// Assumes STAGES >= 2. Output lags the input by STAGES clock edges.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
// Module: gpio_port_regs
// Data and direction storage for one port. A direction bit of 1 means output.
// Assumes the write strobes are already qualified by address decode.
module gpio_port_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q
);
    // Capture data register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_we) begin
            data_q <= wdata;
        end
    end

    // Capture direction register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
// Module: gpio_pin_mux
// Per-pin ownership mux and read-back select for one port.
// Claimed pins are driven by the alternate interface. Read-back uses the stored
// bit for output pins and the synchronized level for input pins.
// Assumes own, alt_* and the register values are stable within a cycle.
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] gpio_data,
    input  logic [W-1:0] gpio_dir,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pin_out[i] = own[i] ? alt_out[i] : gpio_data[i];
        assign pin_oe[i]  = own[i] ? alt_oe[i]  : gpio_dir[i];
        assign rd_val[i]  = gpio_dir[i] ? gpio_data[i] : pin_sync[i];
    end

endmodule

// File: rtl/gpio_altmux_port.sv
`timescale 1ns/1ps
// Module: gpio_altmux_port (top)
// Two GPIO ports (2-pin control, PD_W-pin data) behind a single-cycle register bus.
// The die-to-die interface can claim pins. Read data is combinational from bus_addr.
// Assumes NARROW_W < PD_W <= BUS_W and BASE_ADDR + 3 fits in ADDR_W bits.
module gpio_altmux_port
    import gpio_port_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                BUS_W       = 8,
    parameter int                PD_W        = 8,
    parameter int                NARROW_W    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [1:0]        pc_in,
    output logic [1:0]        pc_out,
    output logic [1:0]        pc_oe,
    input  logic [PD_W-1:0]   pd_in,
    output logic [PD_W-1:0]   pd_out,
    output logic [PD_W-1:0]   pd_oe,
    input  logic              alt_en,
    input  logic              alt_wide,
    input  logic [1:0]        alt_ctl_out,
    input  logic [1:0]        alt_ctl_oe,
    input  logic [PD_W-1:0]   alt_dat_out,
    input  logic [PD_W-1:0]   alt_dat_oe
);
    localparam int PC_W = 2;

    logic [ADDR_W-1:0] addr_off;
    logic              addr_hit;
    reg_sel_e          sel;

    logic [PC_W-1:0] pc_data_q, pc_dir_q, pc_sync, pc_rd, pc_own;
    logic [PD_W-1:0] pd_data_q, pd_dir_q, pd_sync, pd_rd, pd_own;

    // Decode the bus address into a register select.
    always_comb begin
        addr_off = bus_addr - BASE_ADDR;
        addr_hit = (bus_addr >= BASE_ADDR) && (addr_off < ADDR_W'(NUM_REGS));
        sel      = addr_hit ? sel_from_offset(addr_off[1:0]) : RSEL_NONE;
    end

    gpio_port_regs #(.W(PC_W)) u_regs_c (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (bus_we && (sel == RSEL_C_DATA)),
        .dir_we  (bus_we && (sel == RSEL_C_DIR)),
        .wdata   (bus_wdata[PC_W-1:0]),
        .data_q  (pc_data_q),
        .dir_q   (pc_dir_q)
    );

    gpio_port_regs #(.W(PD_W)) u_regs_d (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (bus_we && (sel == RSEL_D_DATA)),
        .dir_we  (bus_we && (sel == RSEL_D_DIR)),
        .wdata   (bus_wdata[PD_W-1:0]),
        .data_q  (pd_data_q),
        .dir_q   (pd_dir_q)
    );

    gpio_sync #(.W(PC_W), .STAGES(SYNC_STAGES)) u_sync_c (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pc_in),
        .dout  (pc_sync)
    );

    gpio_sync #(.W(PD_W), .STAGES(SYNC_STAGES)) u_sync_d (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pd_in),
        .dout  (pd_sync)
    );

    // Control pins are claimed together; data pins by enable and width mode.
    assign pc_own = {PC_W{alt_en}};
    for (genvar i = 0; i < PD_W; i++) begin : g_own
        if (i < NARROW_W) begin : g_low
            assign pd_own[i] = alt_en;
        end else begin : g_high
            assign pd_own[i] = alt_en & alt_wide;
        end
    end

    gpio_pin_mux #(.W(PC_W)) u_mux_c (
        .own       (pc_own),
        .gpio_data (pc_data_q),
        .gpio_dir  (pc_dir_q),
        .alt_out   (alt_ctl_out),
        .alt_oe    (alt_ctl_oe),
        .pin_sync  (pc_sync),
        .pin_out   (pc_out),
        .pin_oe    (pc_oe),
        .rd_val    (pc_rd)
    );

    gpio_pin_mux #(.W(PD_W)) u_mux_d (
        .own       (pd_own),
        .gpio_data (pd_data_q),
        .gpio_dir  (pd_dir_q),
        .alt_out   (alt_dat_out),
        .alt_oe    (alt_dat_oe),
        .pin_sync  (pd_sync),
        .pin_out   (pd_out),
        .pin_oe    (pd_oe),
        .rd_val    (pd_rd)
    );

    // Select read data; unmapped addresses return zero.
    always_comb begin
        case (sel)
            RSEL_C_DATA: bus_rdata = BUS_W'(pc_rd);
            RSEL_D_DATA: bus_rdata = BUS_W'(pd_rd);
            RSEL_C_DIR:  bus_rdata = BUS_W'(pc_dir_q);
            RSEL_D_DIR:  bus_rdata = BUS_W'(pd_dir_q);
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_altmux_port_chk.sv
`timescale 1ns/1ps
// Module: gpio_altmux_port_chk
// Property checker bound into gpio_altmux_port. It observes the ports and the stored registers.
// Assumes NARROW_W < PD_W. The latency check is built only for a two-stage synchronizer.
module gpio_altmux_port_chk #(
    parameter int                ADDR_W      = 8,
    parameter int                BUS_W       = 8,
    parameter int                PD_W        = 8,
    parameter int                NARROW_W    = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PD_W-1:0]   pd_in,
    input logic [1:0]        pc_out,
    input logic [1:0]        pc_oe,
    input logic [PD_W-1:0]   pd_out,
    input logic [PD_W-1:0]   pd_oe,
    input logic              alt_en,
    input logic              alt_wide,
    input logic [1:0]        alt_ctl_out,
    input logic [1:0]        alt_ctl_oe,
    input logic [PD_W-1:0]   alt_dat_out,
    input logic [PD_W-1:0]   alt_dat_oe,
    input logic [1:0]        pc_data_q,
    input logic [PD_W-1:0]   pd_data_q,
    input logic [PD_W-1:0]   pd_dir_q
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(3);
    localparam logic [ADDR_W-1:0] PD_ADDR   = BASE_ADDR + ADDR_W'(1);

    // R1: registers are clear on the first cycle out of reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pd_data_q == '0 && pd_dir_q == '0 && pc_data_q == '0));

    // R2, R11: a data-port write lands at the next edge whatever the ownership.
    a_r2_pd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == PD_ADDR) |=> (pd_data_q == $past(bus_wdata[PD_W-1:0])));

    // R3: control-port upper read bits are zero.
    a_r3_pc_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == BASE_ADDR || bus_addr == BASE_ADDR + ADDR_W'(2))
            |-> (bus_rdata[BUS_W-1:2] == '0));

    // R6: unmapped reads return zero.
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < BASE_ADDR || bus_addr > LAST_ADDR) |-> (bus_rdata == '0));

    // R7: unclaimed data pins follow their registers.
    a_r7_idle_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |-> (pd_out == pd_data_q && pd_oe == pd_dir_q));

    // R8: control pins follow the interface when it is enabled.
    a_r8_ctl_alt: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en |-> (pc_out == alt_ctl_out && pc_oe == alt_ctl_oe));

    // R9: wide mode hands every data pin to the interface.
    a_r9_wide_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && alt_wide) |-> (pd_out == alt_dat_out && pd_oe == alt_dat_oe));

    // R10: narrow mode leaves the upper data pins to the registers.
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && !alt_wide) |->
            (pd_out[PD_W-1:NARROW_W] == pd_data_q[PD_W-1:NARROW_W] &&
             pd_oe[PD_W-1:NARROW_W]  == pd_dir_q[PD_W-1:NARROW_W] &&
             pd_out[NARROW_W-1:0]    == alt_dat_out[NARROW_W-1:0]));

    if (SYNC_STAGES == 2) begin : g_lat
        logic [1:0] up_cnt;

        // Count edges since reset so the history window is valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                up_cnt <= '0;
            end else if (up_cnt != 2'd2) begin
                up_cnt <= up_cnt + 2'd1;
            end
        end

        // R5: all-input data-port reads show the pin level from two edges earlier.
        a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (up_cnt == 2'd2 && bus_addr == PD_ADDR && pd_dir_q == '0)
                |-> (bus_rdata[PD_W-1:0] == $past(pd_in, 2)));
    end

endmodule

bind gpio_altmux_port gpio_altmux_port_chk #(
    .ADDR_W      (ADDR_W),
    .BUS_W       (BUS_W),
    .PD_W        (PD_W),
    .NARROW_W    (NARROW_W),
    .SYNC_STAGES (SYNC_STAGES),
    .BASE_ADDR   (BASE_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pd_in       (pd_in),
    .pc_out      (pc_out),
    .pc_oe       (pc_oe),
    .pd_out      (pd_out),
    .pd_oe       (pd_oe),
    .alt_en      (alt_en),
    .alt_wide    (alt_wide),
    .alt_ctl_out (alt_ctl_out),
    .alt_ctl_oe  (alt_ctl_oe),
    .alt_dat_out (alt_dat_out),
    .alt_dat_oe  (alt_dat_oe),
    .pc_data_q   (pc_data_q),
    .pd_data_q   (pd_data_q),
    .pd_dir_q    (pd_dir_q)
);

// File: tb/gpio_altmux_port_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected values and a monitor pops and compares them.
module gpio_altmux_port_bench;

    localparam logic [7:0] A_CD   = 8'h04;
    localparam logic [7:0] A_DD   = 8'h05;
    localparam logic [7:0] A_CDIR = 8'h06;
    localparam logic [7:0] A_DDIR = 8'h07;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] pc_in = '0, pc_out, pc_oe;
    logic [7:0] pd_in = '0, pd_out, pd_oe;
    logic       alt_en = 1'b0, alt_wide = 1'b0;
    logic [1:0] alt_ctl_out = '0, alt_ctl_oe = '0;
    logic [7:0] alt_dat_out = '0, alt_dat_oe = '0;

    always #2.5 clk = ~clk;

    gpio_altmux_port u_gpio_altmux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .alt_en(alt_en), .alt_wide(alt_wide),
        .alt_ctl_out(alt_ctl_out), .alt_ctl_oe(alt_ctl_oe),
        .alt_dat_out(alt_dat_out), .alt_dat_oe(alt_dat_oe)
    );

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    event     sample_ev;
    int       total = 0;
    int       bad = 0;
    bit       done = 1'b0;

    task automatic note(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: pop each queued expectation and compare it with the bus read data.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                rd_item_t it;
                it = exp_q.pop_front();
                note(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        exp_q.push_back('{addr: a, exp: e, tag: tag});
        #1;
        ->sample_ev;
        #0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        note(act === exp, tag, act, exp);
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(A_CD, 8'h00, "R1 ctl data");
        rd(A_DD, 8'h00, "R1 dat data");
        rd(A_CDIR, 8'h00, "R1 ctl dir");
        rd(A_DDIR, 8'h00, "R1 dat dir");
        chk("R1 dat oe", pd_oe, 8'h00);
        chk("R1 ctl oe", {6'b0, pc_oe}, 8'h00);

        // R2, R4, R7: outputs driven from the registers.
        wr(A_DDIR, 8'hFF);
        wr(A_DD, 8'hA5);
        rd(A_DDIR, 8'hFF, "R2 dat dir");
        rd(A_DD, 8'hA5, "R4 dat output readback");
        chk("R7 dat out", pd_out, 8'hA5);
        chk("R7 dat oe", pd_oe, 8'hFF);

        // R3: control port keeps only two bits.
        wr(A_CD, 8'hFF);
        wr(A_CDIR, 8'hFF);
        rd(A_CD, 8'h03, "R3 ctl data");
        rd(A_CDIR, 8'h03, "R3 ctl dir");
        chk("R7 ctl out", {6'b0, pc_out}, 8'h03);

        // R5: synchronizer latency on the data port.
        wr(A_DDIR, 8'h00);
        chk("R7 dat oe input", pd_oe, 8'h00);
        @(negedge clk);
        pd_in = 8'h3C;
        rd(A_DD, 8'h00, "R5 one edge");
        rd(A_DD, 8'h3C, "R5 two edges");

        // R4, R5: mixed directions.
        wr(A_DDIR, 8'h0F);
        rd(A_DD, 8'h35, "R4 R5 mixed");

        // R5: control port input.
        wr(A_CDIR, 8'h00);
        @(negedge clk);
        pc_in = 2'b10;
        repeat (2) @(negedge clk);
        rd(A_CD, 8'h02, "R5 ctl input");

        // R6: unmapped addresses.
        rd(8'h00, 8'h00, "R6 addr 00");
        rd(8'h03, 8'h00, "R6 addr 03");
        rd(8'h08, 8'h00, "R6 addr 08");
        rd(8'hFF, 8'h00, "R6 addr FF");
        wr(8'h09, 8'hFF);
        wr(8'h03, 8'hFF);
        rd(A_DDIR, 8'h0F, "R6 dat dir kept");
        rd(A_CDIR, 8'h00, "R6 ctl dir kept");
        rd(A_DD, 8'h35, "R6 dat data kept");

        // R8, R9: wide mode.
        @(negedge clk);
        alt_dat_out = 8'h5A;
        alt_dat_oe  = 8'hC3;
        alt_ctl_out = 2'b01;
        alt_ctl_oe  = 2'b11;
        alt_wide    = 1'b1;
        alt_en      = 1'b1;
        #1;
        chk("R9 wide out", pd_out, 8'h5A);
        chk("R9 wide oe", pd_oe, 8'hC3);
        chk("R8 ctl out", {6'b0, pc_out}, 8'h01);
        chk("R8 ctl oe", {6'b0, pc_oe}, 8'h03);

        // R10: narrow mode.
        @(negedge clk);
        alt_wide = 1'b0;
        #1;
        chk("R10 narrow out", pd_out, 8'hAA);
        chk("R10 narrow oe", pd_oe, 8'h03);

        // R11: writes while claimed.
        wr(A_DD, 8'h96);
        wr(A_DDIR, 8'hFF);
        #1;
        chk("R11 narrow out after write", pd_out, 8'h9A);
        chk("R11 narrow oe after write", pd_oe, 8'hF3);
        rd(A_DD, 8'h96, "R11 readback while claimed");
        @(negedge clk);
        alt_en = 1'b0;
        #1;
        chk("R11 released out", pd_out, 8'h96);
        chk("R11 released oe", pd_oe, 8'hFF);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule